// File: doc/BRIEF.md
# Processor Probe Queue Controller

This block takes coherence probes from a system agent and keeps up to eight of them in an internal queue. It serves the probes one at a time, oldest first. For each probe it reads the matching line from an external second-level cache through a request/acknowledge lookup port. It then works out the line's next state from the probe's 3-bit next-state code and returns a response through a valid/ready handshake. A queue slot is freed only when its response handshake completes.

By default every lookup fetches the tag and the data block together. When the tag-only configuration input is high, the first lookup reads tags only, and a hit is followed by a second lookup that fetches the data. A 2-bit saturating hit-history counter follows recent first-lookup outcomes in tag-only mode. While the counter is at 2 or more, the first lookup fetches the data as well and no retry is needed.

The sender side holds a credit counter, so the system can never hand over more probes than the queue can hold. A probe that carries the reserved next-state code sets a sticky error flag.

Top module: `probe_queue_ctrl`

## Requirements
- R1: After reset the credit count is 8, `prb_ready_o` is 1, and `lk_req_o`, `rsp_valid_o` and `err_o` are 0.
- R2: The credit count drops by one for each accepted probe (`prb_valid_i` and `prb_ready_o` both high) and rises by one for each response handshake (`rsp_valid_i` and `rsp_ready_i` both high). When both happen in the same cycle the count is unchanged. The count stays within 0 to 8, and `prb_ready_o` is 0 exactly when the count is 0.
- R3: The queue holds 8 probes. Eight accepted probes with no response handshake bring the credit count to 0. A probe offered at that point is not accepted and produces no response.
- R4: Responses leave in arrival order. `rsp_idx_o` is the queue slot of the probe, which equals the number of probes accepted before it, modulo 8. A pending response keeps its index stable until it is taken.
- R5: With tag-only mode off, each probe makes exactly one lookup, with `lk_data_o` set to 1.
- R6: With tag-only mode on and a history count below 2, the first lookup has `lk_data_o` set to 0. A hit then causes a second lookup with `lk_data_o` set to 1. A miss causes no second lookup. A lookup request holds its fields until it is acknowledged.
- R7: The hit-history count resets to 0. In tag-only mode it saturates between 0 and 3, going up on a first-lookup hit and down on a first-lookup miss. At 2 or more the first lookup carries `lk_data_o`=1 and no retry follows.
- R8: Line states are encoded as 0 Invalid, 1 Clean, 2 Clean/Shared, 3 Dirty, 4 Dirty/Shared. On a hit, code 3'b101 gives a next state of Invalid.
- R9: On a hit, code 3'b110 turns Clean into Clean/Shared and Dirty into Dirty/Shared, and leaves the shared states as they are. Codes 3'b000 to 3'b100 leave the state unchanged.
- R10: Code 3'b111 is reserved. It leaves the state unchanged, and `err_o` goes to 1 in the cycle after the probe is accepted. `err_o` then stays at 1 until reset.
- R11: `rsp_hit_o` gives the hit result of the last lookup. `rsp_dirty_o` is 1 for a hit on a Dirty or Dirty/Shared line. A miss reports dirty 0 and state Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_only_i | input | 1 | Tag-only lookup mode enable |
| prb_valid_i | input | 1 | Probe offered by the system |
| prb_ready_o | output | 1 | Probe can be accepted (credit available) |
| prb_addr_i | input | AW (16) | Probe line address |
| prb_code_i | input | 3 | Next-state code |
| credit_o | output | 4 | Credits held by the sender |
| lk_req_o | output | 1 | Cache lookup request |
| lk_addr_o | output | AW (16) | Lookup address |
| lk_data_o | output | 1 | Lookup also fetches the data block |
| lk_ack_i | input | 1 | Lookup done, result valid |
| lk_hit_i | input | 1 | Lookup hit |
| lk_state_i | input | 3 | Current line state |
| rsp_valid_o | output | 1 | Probe response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_hit_o | output | 1 | Probe hit |
| rsp_dirty_o | output | 1 | Line was dirty |
| rsp_idx_o | output | 3 | Queue slot of the probe |
| rsp_state_o | output | 3 | Next line state |
| err_o | output | 1 | Sticky reserved-code error |

## Verification
The assertions check a set of invariants on every cycle:
- the credit range, and that credit plus queue occupancy always equals 8;
- no push into a full queue and no pop from an empty one;
- a pending response keeps its index, and a pending lookup keeps its request fields;
- the error flag is sticky;
- a miss never reports a dirty line;
- the history counter saturates.

The directed scenarios are needed for the rest: the next-state mapping for each code, the lookup count and data flag as the history counter moves through its range, strict response order across a full queue, a blocked ninth probe, and the credit holding steady when an accept and a release fall in the same cycle.

// File: rtl/probe_pkg.sv
`timescale 1ns/1ps
package probe_pkg;
  localparam logic [2:0] LS_INV      = 3'd0;
  localparam logic [2:0] LS_CLEAN    = 3'd1;
  localparam logic [2:0] LS_CLEAN_SH = 3'd2;
  localparam logic [2:0] LS_DIRTY    = 3'd3;
  localparam logic [2:0] LS_DIRTY_SH = 3'd4;

  localparam logic [2:0] CODE_INVAL = 3'b101;
  localparam logic [2:0] CODE_SHARE = 3'b110;
  localparam logic [2:0] CODE_RSVD  = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_DATA, S_RSP} fsm_e;

  function automatic logic [2:0] next_line_state(logic [2:0] code, logic [2:0] cur);
    logic [2:0] nxt;
    nxt = cur;
    if (code == CODE_INVAL) nxt = LS_INV;
    else if (code == CODE_SHARE) begin
      if (cur == LS_CLEAN)      nxt = LS_CLEAN_SH;
      else if (cur == LS_DIRTY) nxt = LS_DIRTY_SH;
    end
    return nxt;
  endfunction

  function automatic logic is_dirty(logic [2:0] st);
    return (st == LS_DIRTY) || (st == LS_DIRTY_SH);
  endfunction
endpackage

// File: rtl/probe_fifo.sv
`timescale 1ns/1ps
module probe_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 19,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [IW-1:0] head_idx_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign data_o     = mem_q[rd_q];
  assign head_idx_o = rd_q;
  assign empty_o    = (cnt_q == '0);
  assign count_o    = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (int'(cnt_q) < DEPTH || pop_i)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R3
endmodule

// File: rtl/probe_credit.sv
`timescale 1ns/1ps
module probe_credit #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  output logic [CW-1:0] credit_o
);
  logic [CW-1:0] cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cr_q <= CW'(DEPTH);
    else if (take_i && !give_i) cr_q <= cr_q - 1'b1;
    else if (give_i && !take_i) cr_q <= cr_q + 1'b1;
  end

  assign credit_o = cr_q;

  AST_CREDIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cr_q) <= DEPTH); // R2
  AST_NO_CREDIT_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_q == '0) |-> !take_i); // R2
endmodule

// File: rtl/hit_history.sv
`timescale 1ns/1ps
module hit_history #(
  parameter int HW     = 2,
  parameter int THRESH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic hit_i,
  output logic fetch_o
);
  localparam logic [HW-1:0] MAXV = '1;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (upd_i) begin
      if (hit_i && cnt_q != MAXV)     cnt_q <= cnt_q + 1'b1;
      else if (!hit_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fetch_o = (int'(cnt_q) >= THRESH);

  AST_HIST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAXV && upd_i && hit_i) |=> cnt_q == MAXV); // R7
  AST_HIST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && upd_i && !hit_i) |=> cnt_q == '0); // R7
endmodule

// File: rtl/probe_queue_ctrl.sv
`timescale 1ns/1ps
module probe_queue_ctrl
  import probe_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = AW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tag_only_i,
  input  logic          prb_valid_i,
  output logic          prb_ready_o,
  input  logic [AW-1:0] prb_addr_i,
  input  logic [2:0]    prb_code_i,
  output logic [CW-1:0] credit_o,
  output logic          lk_req_o,
  output logic [AW-1:0] lk_addr_o,
  output logic          lk_data_o,
  input  logic          lk_ack_i,
  input  logic          lk_hit_i,
  input  logic [2:0]    lk_state_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic          rsp_hit_o,
  output logic          rsp_dirty_o,
  output logic [IW-1:0] rsp_idx_o,
  output logic [2:0]    rsp_state_o,
  output logic          err_o
);
  fsm_e state_q, state_d;
  logic accept, release_s, empty, hist_fetch, first_data, hist_upd;
  logic [EW-1:0] head;
  logic [CW-1:0] q_count;
  logic [IW-1:0] head_idx;
  logic [2:0] head_code, st_q;
  logic hit_q, err_q;

  assign accept    = prb_valid_i && prb_ready_o;
  assign release_s = rsp_valid_o && rsp_ready_i;

  probe_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(accept), .data_i({prb_code_i, prb_addr_i}),
    .pop_i(release_s), .data_o(head),
    .head_idx_o(head_idx), .empty_o(empty), .count_o(q_count)
  );

  probe_credit #(.DEPTH(DEPTH)) u_credit (
    .clk_i, .rst_ni, .take_i(accept), .give_i(release_s), .credit_o(credit_o)
  );

  assign hist_upd = tag_only_i && state_q == S_TAG && lk_ack_i;

  hit_history #(.HW(2), .THRESH(2)) u_hist (
    .clk_i, .rst_ni, .upd_i(hist_upd), .hit_i(lk_hit_i), .fetch_o(hist_fetch)
  );

  assign prb_ready_o = (credit_o != '0);
  assign head_code   = head[EW-1:AW];
  assign first_data  = !tag_only_i || hist_fetch;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (!empty) state_d = S_TAG;
      S_TAG:  if (lk_ack_i)
                state_d = (!first_data && lk_hit_i) ? S_DATA : S_RSP;
      S_DATA: if (lk_ack_i) state_d = S_RSP;
      S_RSP:  if (rsp_ready_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hit_q   <= 1'b0;
      st_q    <= LS_INV;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == S_TAG || state_q == S_DATA) && lk_ack_i) begin
        hit_q <= lk_hit_i;
        st_q  <= lk_state_i;
      end
      if (accept && prb_code_i == CODE_RSVD) err_q <= 1'b1;
    end
  end

  assign lk_req_o    = (state_q == S_TAG) || (state_q == S_DATA);
  assign lk_addr_o   = head[AW-1:0];
  assign lk_data_o   = (state_q == S_DATA) || first_data;
  assign rsp_valid_o = (state_q == S_RSP);
  assign rsp_hit_o   = hit_q;
  assign rsp_dirty_o = hit_q && is_dirty(st_q);
  assign rsp_idx_o   = head_idx;
  assign rsp_state_o = hit_q ? next_line_state(head_code, st_q) : LS_INV;
  assign err_o       = err_q;

  AST_CREDIT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit_o) + int'(q_count) == DEPTH); // R3
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_idx_o)); // R4
  AST_LK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_o && !lk_ack_i) |=> lk_req_o && $stable(lk_data_o) && $stable(lk_addr_o)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (!rsp_dirty_o && rsp_state_o == LS_INV)); // R11
endmodule

// File: tb/probe_queue_ctrl_tb.sv
`timescale 1ns/1ps
module probe_queue_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tag_only_i = 1'b0;
  logic prb_valid_i = 1'b0;
  logic prb_ready_o;
  logic [15:0] prb_addr_i = '0;
  logic [2:0] prb_code_i = '0;
  logic [3:0] credit_o;
  logic lk_req_o, lk_data_o;
  logic [15:0] lk_addr_o;
  logic lk_ack_i;
  logic lk_hit_i = 1'b0;
  logic [2:0] lk_state_i = 3'd0;
  logic rsp_valid_o;
  logic rsp_ready_i = 1'b0;
  logic rsp_hit_o, rsp_dirty_o, err_o;
  logic [2:0] rsp_idx_o, rsp_state_o;

  int checks = 0;
  int errors = 0;
  int n_acc = 0;
  int n_rsp = 0;
  int lk_base = 0;
  int lk_n;
  logic lk_log [64];

  always #2 clk = ~clk;

  probe_queue_ctrl dut_i (
    .clk_i(clk), .rst_ni, .tag_only_i, .prb_valid_i, .prb_ready_o,
    .prb_addr_i, .prb_code_i, .credit_o, .lk_req_o, .lk_addr_o, .lk_data_o,
    .lk_ack_i, .lk_hit_i, .lk_state_i, .rsp_valid_o, .rsp_ready_i,
    .rsp_hit_o, .rsp_dirty_o, .rsp_idx_o, .rsp_state_o, .err_o
  );

  // cache model: acknowledge each request one cycle after it appears
  always @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_ack_i <= 1'b0;
      lk_n     <= 0;
    end else if (lk_req_o && !lk_ack_i) begin
      lk_ack_i <= 1'b1;
      lk_log[lk_n % 64] <= lk_data_o;
      lk_n <= lk_n + 1;
    end else lk_ack_i <= 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [2:0] c);
    @(negedge clk);
    chk("R2 ready before send", int'(prb_ready_o), 1);
    prb_addr_i = a; prb_code_i = c; prb_valid_i = 1'b1;
    @(negedge clk);
    prb_valid_i = 1'b0;
    n_acc++;
    chk("R2 credit after accept", int'(credit_o), 8 - (n_acc - n_rsp));
  endtask

  task automatic take_rsp(input string req, input int hit, input int dirty,
                          input int st, input int n_lk, input int d0);
    int w;
    w = 0;
    while (!rsp_valid_o && w < 200) begin @(negedge clk); w++; end
    chk({req, " rsp valid"}, int'(rsp_valid_o), 1);
    chk({req, " hit"}, int'(rsp_hit_o), hit);
    chk({req, " dirty"}, int'(rsp_dirty_o), dirty);
    chk({req, " state"}, int'(rsp_state_o), st);
    chk("R4 idx", int'(rsp_idx_o), n_rsp % 8);
    chk({req, " lookups"}, lk_n - lk_base, n_lk);
    chk({req, " first data"}, int'(lk_log[lk_base % 64]), d0);
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    n_rsp++;
    lk_base = lk_n;
    chk("R2 credit after release", int'(credit_o), 8 - (n_acc - n_rsp));
  endtask

  task automatic probe(input string req, input logic [2:0] code, input int hit,
                       input int st_in, input int dirty, input int st_out,
                       input int n_lk, input int d0);
    lk_hit_i = hit[0]; lk_state_i = st_in[2:0];
    send(16'h1000 + 16'(n_acc), code);
    take_rsp(req, hit, dirty, st_out, n_lk, d0);
  endtask

  task automatic t_reset();
    chk("R1 credit", int'(credit_o), 8);
    chk("R1 ready", int'(prb_ready_o), 1);
    chk("R1 lk_req", int'(lk_req_o), 0);
    chk("R1 rsp_valid", int'(rsp_valid_o), 0);
    chk("R1 err", int'(err_o), 0);
  endtask

  task automatic t_default();
    tag_only_i = 1'b0;
    probe("R5 R9 share clean", 3'b110, 1, 1, 0, 2, 1, 1);
    probe("R9 R11 share dirty", 3'b110, 1, 3, 1, 4, 1, 1);
    probe("R9 share on shared", 3'b110, 1, 2, 0, 2, 1, 1);
    probe("R8 inval dirty", 3'b101, 1, 3, 1, 0, 1, 1);
    probe("R9 code000 unchanged", 3'b000, 1, 1, 0, 1, 1, 1);
    probe("R11 miss", 3'b110, 0, 3, 0, 0, 1, 1);
  endtask

  task automatic t_tag_only();
    tag_only_i = 1'b1;
    probe("R6 miss no retry", 3'b000, 0, 0, 0, 0, 1, 0);   // hist 0
    probe("R6 hit retry", 3'b000, 1, 1, 0, 1, 2, 0);       // hist 1
    probe("R7 hit retry h1", 3'b000, 1, 1, 0, 1, 2, 0);    // hist 2
    probe("R7 fetch with tag", 3'b110, 1, 1, 0, 2, 1, 1);  // hist 3
    probe("R7 saturate", 3'b000, 1, 3, 1, 3, 1, 1);        // hist 3
    probe("R7 miss h3", 3'b000, 0, 0, 0, 0, 1, 1);         // hist 2
    probe("R7 miss h2", 3'b000, 0, 0, 0, 0, 1, 1);         // hist 1
    probe("R7 back to retry", 3'b000, 1, 1, 0, 1, 2, 0);   // hist 2
    tag_only_i = 1'b0;
  endtask

  task automatic t_reserved();
    chk("R10 err before", int'(err_o), 0);
    lk_hit_i = 1'b1; lk_state_i = 3'd3;
    send(16'h2222, 3'b111);
    chk("R10 err set", int'(err_o), 1);
    take_rsp("R10 rsvd unchanged", 1, 1, 3, 1, 1);
    probe("R10 later probe", 3'b000, 1, 1, 0, 1, 1, 1);
    chk("R10 err sticky", int'(err_o), 1);
  endtask

  task automatic t_fill();
    lk_hit_i = 1'b1; lk_state_i = 3'd1;
    for (int i = 0; i < 8; i++) send(16'h3000 + 16'(i), 3'b000);
    chk("R3 credit zero", int'(credit_o), 0);
    chk("R3 ready low", int'(prb_ready_o), 0);
    @(negedge clk);
    prb_addr_i = 16'h3999; prb_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    prb_valid_i = 1'b0;
    chk("R3 ninth ignored credit", int'(credit_o), 0);
    for (int i = 0; i < 7; i++) take_rsp("R4 drain", 1, 0, 1, 1, 1);
    // same-cycle accept and release
    while (!rsp_valid_o) @(negedge clk);
    prb_addr_i = 16'h3aaa; prb_code_i = 3'b000;
    prb_valid_i = 1'b1; rsp_ready_i = 1'b1;
    @(negedge clk);
    prb_valid_i = 1'b0; rsp_ready_i = 1'b0;
    n_acc++; n_rsp++; lk_base = lk_n;
    chk("R2 credit same cycle", int'(credit_o), 7);
    take_rsp("R4 last", 1, 0, 1, 1, 1);
    repeat (10) @(negedge clk);
    chk("R3 no extra rsp", int'(rsp_valid_o), 0);
    chk("R3 final credit", int'(credit_o), 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_tag_only();
    t_reserved();
    t_fill();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule